// File: doc/BRIEF.md
# Half-Bridge Output Mode Router with Dead-Time Insertion

This block sits between a logic-level PWM modulator and four half-bridge power output stages. For each stage it produces a high-side gate enable and a low-side gate enable. Four PWM inputs and a 3-bit mode code set how the block routes those inputs to the stages. Some modes pass the inputs straight through, because the bridge pairs were inverted outside the block. Other modes build the complementary legs of a bridge inside the block, by inverting one input and fanning it out to several stages.

The four stages form two pairs. Stages 0 and 1 are pair 0, and stages 2 and 3 are pair 1. Each pair has an active-low reset and a request input from protection logic that forces the pair to high impedance. Each pair takes the mode code at the moment its reset is released and keeps that code until its next reset. In every stage, both enables go low whenever the routed level changes. The enable of the new side comes on only after the routed level has stayed constant for a set number of clock cycles, so the two transistors of a leg are never on together.

Top module: `hbr_mode_router`

## Requirements
- R1: While the synchronous active-high `rst` is high, every high-side and low-side enable reads 0. After `rst` falls, each pair restarts as if its reset had just been released.
- R2: While `pair_rst_n[p]` is 0, both enables of both stages of pair p are 0 (pair 0 = stages 0,1; pair 1 = stages 2,3).
- R3: A pair takes `cfg_code` at the clock edge where `pair_rst_n[p]` is first sampled high. Any later change on `cfg_code` has no effect on that pair's routing until the pair is reset again.
- R4: Codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b111 route `pwm_in[i]` unchanged to stage i, for i = 0..3.
- R5: Code 3'b100 routes pwm_in[0] to stage 0, NOT pwm_in[0] to stage 1, pwm_in[2] to stage 2 and NOT pwm_in[2] to stage 3. Inputs 1 and 3 are unused.
- R6: Code 3'b101 routes pwm_in[0], pwm_in[1] and pwm_in[2] to stages 0, 1 and 2, and NOT pwm_in[2] to stage 3.
- R7: Code 3'b110 routes pwm_in[0] to stages 0 and 2 and NOT pwm_in[0] to stages 1 and 3. The other inputs are unused.
- R8: The high-side enable of a stage follows a routed 1 and the low-side enable follows a routed 0. After the routed level changes at a clock edge, both enables are 0 for exactly DEAD_CYCLES cycles. The new side then turns on, provided the routed level held throughout.
- R9: The high-side and low-side enables of a stage are never 1 at the same time.
- R10: A routed pulse that lasts DEAD_CYCLES cycles or fewer never turns on the side it would select.
- R11: `hiz_req[p]` forces both enables of pair p to 0 in the same cycle, without a clock edge. Once it drops, an enable returns only after DEAD_CYCLES+1 edges of stable routed level.
- R12: After a pair leaves reset with a constant routed level, its enables turn on at the (DEAD_CYCLES+1)-th edge after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| pair_rst_n | input | 2 | Per-pair active-low reset; bit p controls pair p |
| hiz_req | input | 2 | Per-pair high-impedance request from protection logic |
| cfg_code | input | 3 | Output mode code, taken at pair reset release |
| pwm_in | input | 4 | Logic-level PWM inputs |
| hi_en | output | 4 | High-side gate enable, one bit per stage |
| lo_en | output | 4 | Low-side gate enable, one bit per stage |

## Verification
If a pair loaded the wrong mode, or reloaded it while running, the fault shows as one or more stages driving the wrong polarity. That becomes visible DEAD_CYCLES+1 edges after the routed level settles. A dead-time counter that is off by one moves the turn-on edge by one cycle on every transition, so a reference that counts stable edges exposes it on the first toggle. A counter that fails to restart on a short pulse shows up as a spurious enable pulse. A high-impedance gate that is registered rather than direct leaves an enable set for one cycle after the request, and a mid-cycle probe catches that.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int NUM_STAGES = 4;
    localparam int NUM_PAIRS  = NUM_STAGES / 2;

    typedef enum logic [2:0] {
        MODE_FB_EXT     = 3'b000,
        MODE_SPLIT_EXT  = 3'b001,
        MODE_PAR_EXT    = 3'b010,
        MODE_QUAD_A     = 3'b011,
        MODE_FB_INT     = 3'b100,
        MODE_SPLIT_INT  = 3'b101,
        MODE_PAR_INT    = 3'b110,
        MODE_QUAD_B     = 3'b111
    } mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    // Level that stage `st` should follow under mode `m`.
    function automatic logic route_stage(mode_e m, logic [3:0] pin, logic [1:0] st);
        logic v;
        case (m)
            MODE_FB_INT:    v = st[0] ? ~pin[st - 2'd1] : pin[st];
            MODE_SPLIT_INT: v = (st == 2'd3) ? ~pin[2] : pin[st];
            MODE_PAR_INT:   v = st[0] ? ~pin[0] : pin[0];
            default:        v = pin[st];
        endcase
        return v;
    endfunction

endpackage

// File: rtl/hbr_pair_ctrl.sv
module hbr_pair_ctrl
    import hbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pair_rst_n,
    input  logic       hiz_req,
    input  logic [2:0] cfg_code,
    output mode_e      mode_o,
    output logic       off_o
);

    logic  run_q;
    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            mode_q <= MODE_FB_EXT;
        end else begin
            run_q <= pair_rst_n;
            if (pair_rst_n && !run_q)
                mode_q <= mode_e'(cfg_code);
        end
    end

    assign mode_o = mode_q;
    assign off_o  = rst | ~run_q | ~pair_rst_n | hiz_req;

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && pair_rst_n) |=> $stable(mode_q));

    // R2
    reset_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pair_rst_n |=> !run_q);

endmodule

// File: rtl/hbr_deadband.sv
module hbr_deadband
    import hbr_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  off_i,
    input  logic  r_i,
    output gate_t g_o
);

    localparam int CNT_W = $clog2(DEAD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYCLES - 1);

    logic            arm_q;
    logic            r_q;
    logic [CNT_W-1:0] cnt_q;
    gate_t           g_q;

    always_ff @(posedge clk) begin
        if (rst || off_i) begin
            arm_q <= 1'b0;
            r_q   <= 1'b0;
            cnt_q <= '0;
            g_q   <= '0;
        end else if (!arm_q || (r_i != r_q)) begin
            arm_q <= 1'b1;
            r_q   <= r_i;
            cnt_q <= '0;
            g_q   <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            g_q.hi <= r_q;
            g_q.lo <= ~r_q;
        end
    end

    assign g_o = off_i ? gate_t'('0) : g_q;

    // R9
    overlap_free_chk: assert property (@(posedge clk) disable iff (rst)
        !(g_o.hi && g_o.lo));

    // R8
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(g_o.hi) |-> $past(!g_o.lo));

    // R8
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(g_o.lo) |-> $past(!g_o.hi));

    // R10
    hi_settled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(g_o.hi) |-> $past(r_i));

endmodule

// File: rtl/hbr_mode_router.sv
module hbr_mode_router
    import hbr_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pair_rst_n,
    input  logic [1:0] hiz_req,
    input  logic [2:0] cfg_code,
    input  logic [3:0] pwm_in,
    output logic [3:0] hi_en,
    output logic [3:0] lo_en
);

    mode_e pair_mode [NUM_PAIRS];
    logic  pair_off  [NUM_PAIRS];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        hbr_pair_ctrl u_ctrl (
            .clk        (clk),
            .rst        (rst),
            .pair_rst_n (pair_rst_n[p]),
            .hiz_req    (hiz_req[p]),
            .cfg_code   (cfg_code),
            .mode_o     (pair_mode[p]),
            .off_o      (pair_off[p])
        );

        // R11
        hiz_cut_chk: assert property (@(posedge clk) disable iff (rst)
            hiz_req[p] |-> (hi_en[2*p +: 2] == 2'b00 && lo_en[2*p +: 2] == 2'b00));

        // R2
        pair_reset_chk: assert property (@(posedge clk) disable iff (rst)
            !pair_rst_n[p] |-> (hi_en[2*p +: 2] == 2'b00 && lo_en[2*p +: 2] == 2'b00));
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        logic  routed;
        gate_t gate;

        assign routed = route_stage(pair_mode[s/2], pwm_in, 2'(s));

        hbr_deadband #(.DEAD_CYCLES(DEAD_CYCLES)) u_db (
            .clk   (clk),
            .rst   (rst),
            .off_i (pair_off[s/2]),
            .r_i   (routed),
            .g_o   (gate)
        );

        assign hi_en[s] = gate.hi;
        assign lo_en[s] = gate.lo;
    end

    // R1
    global_reset_chk: assert property (@(posedge clk)
        rst |=> (hi_en == 4'b0000 && lo_en == 4'b0000));

endmodule

// File: tb/hbr_mode_router_tb_top.sv
`timescale 1ns/1ps
module hbr_mode_router_tb_top;

    localparam int DEAD = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] prn;
    logic [1:0] hiz;
    logic [2:0] cfg;
    logic [3:0] pwm;
    logic [3:0] hi_en;
    logic [3:0] lo_en;

    always #2.5 clk = ~clk;

    hbr_mode_router #(.DEAD_CYCLES(DEAD)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pair_rst_n (prn),
        .hiz_req    (hiz),
        .cfg_code   (cfg),
        .pwm_in     (pwm),
        .hi_en      (hi_en),
        .lo_en      (lo_en)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    typedef struct {
        logic [3:0] hi;
        logic [3:0] lo;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    // Reference state built from the requirements
    logic [1:0] run_m;
    logic [2:0] mode_m [2];
    int         streak [4];
    logic       last_r [4];

    function automatic logic ref_route(logic [2:0] m, logic [3:0] p, int st);
        case (m)
            3'b100: return (st == 0) ? p[0] : (st == 1) ? ~p[0] : (st == 2) ? p[2] : ~p[2];
            3'b101: return (st == 3) ? ~p[2] : p[st];
            3'b110: return (st % 2 == 0) ? p[0] : ~p[0];
            default: return p[st];
        endcase
    endfunction

    // Driver side of the scoreboard: predicts each edge, pushes expectation
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            run_m = 2'b00;
            mode_m[0] = 3'b000;
            mode_m[1] = 3'b000;
            for (int s = 0; s < 4; s++) streak[s] = 0;
        end else begin
            for (int s = 0; s < 4; s++) begin
                int   pr;
                logic r;
                pr = s / 2;
                r  = ref_route(mode_m[pr], pwm, s);
                if (!run_m[pr] || !prn[pr] || hiz[pr]) begin
                    streak[s] = 0;
                end else if (streak[s] > 0 && r == last_r[s]) begin
                    if (streak[s] < 1000) streak[s] = streak[s] + 1;
                end else begin
                    streak[s] = 1;
                    last_r[s] = r;
                end
            end
            for (int pr = 0; pr < 2; pr++) begin
                if (prn[pr] && !run_m[pr]) mode_m[pr] = cfg;
                run_m[pr] = prn[pr];
            end
        end
        for (int s = 0; s < 4; s++) begin
            logic offn;
            offn = rst || !run_m[s/2] || !prn[s/2] || hiz[s/2];
            e.hi[s] = !offn && streak[s] >= DEAD + 1 && last_r[s];
            e.lo[s] = !offn && streak[s] >= DEAD + 1 && !last_r[s];
        end
        e.req = cur_req;
        sb_q.push_back(e);
    end

    // Monitor side: pops and compares after outputs settle
    always @(posedge clk) begin
        #1;
        if (!done && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (hi_en !== e.hi || lo_en !== e.lo) begin
                n_fail++;
                $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b at %0t",
                         e.req, hi_en, lo_en, e.hi, e.lo, $time);
            end
            n_chk++;
            if ((hi_en & lo_en) !== 4'b0000) begin
                n_fail++;
                $display("FAIL R9: overlap hi=%b lo=%b expected overlap 0000", hi_en, lo_en);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic patterns(int hold);
        logic [3:0] pats [4] = '{4'b0101, 4'b1010, 4'b1100, 4'b0011};
        for (int i = 0; i < 4; i++) begin
            pwm = pats[i];
            cyc(hold);
        end
    endtask

    task automatic run_mode(logic [2:0] code, string tag);
        cur_req = "R2";
        prn = 2'b00;
        cyc(3);
        cur_req = tag;
        cfg = code;
        prn = 2'b11;
        cyc(DEAD + 4);
        patterns(DEAD + 4);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; prn = 2'b00; hiz = 2'b00; cfg = 3'b011; pwm = 4'b0000;
        cur_req = "R1";
        cyc(3);
        rst = 1'b0;
        cur_req = "R2";
        cyc(3);

        // R12: release with constant level
        cur_req = "R12";
        pwm = 4'b0101;
        prn = 2'b11;
        cyc(DEAD + 5);

        // R4 and R8 in pass-through quad mode
        cur_req = "R4";
        patterns(DEAD + 4);
        cur_req = "R8";
        for (int i = 0; i < 6; i++) begin
            pwm = ~pwm;
            cyc(DEAD + 2);
        end

        // R3: code change while running has no effect
        cur_req = "R3";
        cfg = 3'b110;
        pwm = 4'b0001;
        cyc(DEAD + 4);
        patterns(DEAD + 3);

        run_mode(3'b100, "R5");
        run_mode(3'b101, "R6");
        run_mode(3'b110, "R7");
        run_mode(3'b000, "R4");
        run_mode(3'b001, "R4");
        run_mode(3'b010, "R4");
        run_mode(3'b111, "R4");

        // R10: short pulses in quad mode
        run_mode(3'b011, "R10");
        pwm = 4'b0000;
        cyc(DEAD + 4);
        pwm = 4'b0001;
        cyc(2);
        pwm = 4'b0000;
        cyc(DEAD + 3);
        pwm = 4'b0010;
        cyc(DEAD);
        pwm = 4'b0000;
        cyc(DEAD + 3);

        // R11: immediate high-impedance on pair 1
        cur_req = "R11";
        pwm = 4'b0100;
        cyc(DEAD + 4);
        @(negedge clk);
        hiz[1] = 1'b1;
        #0.5;
        n_chk++;
        if ((hi_en[3:2] | lo_en[3:2]) !== 2'b00) begin
            n_fail++;
            $display("FAIL R11: pair1 hi=%b lo=%b expected 00/00 same cycle",
                     hi_en[3:2], lo_en[3:2]);
        end
        cyc(3);
        hiz[1] = 1'b0;
        cyc(DEAD + 4);
        hiz[0] = 1'b1;
        cyc(3);
        hiz[0] = 1'b0;
        cyc(DEAD + 4);

        // R1: global reset mid-run
        cur_req = "R1";
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cur_req = "R12";
        cyc(DEAD + 5);

        cyc(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule